// File: doc/BRIEF.md
# Event Memory Bank Writer

This block takes formatted event words from several parallel data lanes during a beam spill and writes each lane into its own memory bank through a plain synchronous RAM write port. Words that match a configurable null pattern are written at the current location without moving the write pointer. The next word then lands on top of them, so the events of a spill sit back to back in each bank with no runs of filler words between them.

A small register file gives a host what it needs to read out a spill. It holds the address of the last real word in each bank and the number of events seen so far. A control bit starts a self-timed fast clear that zeroes every address of every bank, and a status bit reports when that clear has finished. A spill-start pulse rewinds the bank pointers, the event count and the clear-done status for a new spill.

Top module: `evbank_writer`

## Requirements
- R1: A valid non-null word on a lane is written to that lane's bank at the bank's current pointer, and the pointer then advances by one, wrapping at the bank depth.
- R2: A word is null when `((data ^ NULL_WORD) & NULL_MASK) == 0`, with all-zero data by default. A valid null word is written at the current pointer and the pointer does not advance, so the next valid word overwrites it.
- R3: Register addresses 0 to 3 return, zero-extended, the address of the last non-null word written to banks 0 to 3. They read 0 after reset and after spill start.
- R4: Register address 15 returns the spill event count. The count rises by one for each cycle in which lane 0 is valid with its end-of-event flag set. End-of-event flags on the other lanes do not change it.
- R5: A one-cycle `spill_start` pulse sets every bank pointer, every last-address register, the event count and the clear-done bit to zero.
- R6: Writing register address 4 with bit 0 set starts a fast clear. Bit 0 of that register always reads as 0.
- R7: A fast clear writes zero to every address from 0 to DEPTH-1 in ascending order, one address per cycle, with all banks at the same address. It leaves the bank pointers and the last-address registers unchanged.
- R8: Register address 4 bit 2 reads 1 while a clear is in progress. Bit 1 (done) becomes 1 in the cycle after the write to address DEPTH-1 is presented, and it stays 1 across any number of reads.
- R9: While a clear is in progress, lane inputs are ignored: no lane data is written, no pointer moves and no event is counted.
- R10: Write-port outputs change one clock after the lane input is sampled. Register read data is registered one clock after `reg_addr` is sampled.
- R11: After reset, no write strobe is active and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spill_start | input | 1 | Start-of-spill pulse |
| lane_valid | input | NUM_LANES | Per-lane word valid |
| lane_eoe | input | NUM_LANES | Per-lane end-of-event flag |
| lane_data | input | NUM_LANES*DATA_W | Per-lane data words, lane 0 in the low bits |
| mem_we | output | NUM_LANES | Per-bank write enable |
| mem_addr | output | NUM_LANES*ADDR_W | Per-bank write address |
| mem_wdata | output | NUM_LANES*DATA_W | Per-bank write data |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | REG_DW | Register write data |
| reg_rdata | output | REG_DW | Registered read data |

## Verification
The bench builds the block with four lanes, 16-bit words and ADDR_W = 4. The resulting 16-entry banks make a full fast clear short enough to score every one of its writes, and they let the bank pointers run past their top address. The null pattern and mask keep their defaults, so mixing zero and non-zero words exercises squeezing out null words. The bench also drives lane traffic during a clear to show that it is dropped.

// File: rtl/evbw_pkg.sv
package evbw_pkg;
  localparam int REG_AW = 4;
  localparam logic [REG_AW-1:0] RA_CTRL  = 4'd4;
  localparam logic [REG_AW-1:0] RA_EVCNT = 4'd15;
  localparam int CTRL_START_BIT = 0;
  localparam int CTRL_DONE_BIT  = 1;
  localparam int CTRL_BUSY_BIT  = 2;
endpackage

// File: rtl/evbw_lane.sv
module evbw_lane #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6,
  parameter logic [DATA_W-1:0] NULL_WORD = '0,
  parameter logic [DATA_W-1:0] NULL_MASK = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spill_start,
  input  logic              clr_busy,
  input  logic [ADDR_W-1:0] clr_addr,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] last_addr
);
  logic [ADDR_W-1:0] wr_ptr;
  logic              is_null;

  assign is_null = ((in_data ^ NULL_WORD) & NULL_MASK) == '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      we        <= 1'b0;
      addr      <= '0;
      wdata     <= '0;
      wr_ptr    <= '0;
      last_addr <= '0;
    end else begin
      we <= 1'b0;
      if (clr_busy) begin
        we    <= 1'b1;
        addr  <= clr_addr;
        wdata <= '0;
      end else if (in_valid) begin
        we    <= 1'b1;
        addr  <= wr_ptr;
        wdata <= in_data;
        if (!is_null) begin
          wr_ptr    <= wr_ptr + 1'b1;
          last_addr <= wr_ptr;
        end
      end
      if (spill_start) begin
        wr_ptr    <= '0;
        last_addr <= '0;
      end
    end
  end
endmodule

// File: rtl/evbw_clear.sv
module evbw_clear #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              spill_start,
  output logic              busy,
  output logic [ADDR_W-1:0] addr,
  output logic              done
);
  localparam logic [ADDR_W-1:0] LAST = '1;
  logic fin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      addr  <= '0;
      fin_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (fin_q) done <= 1'b1;
      if (start) begin
        busy <= 1'b1;
        addr <= '0;
        done <= 1'b0;
        fin_q <= 1'b0;
      end else if (busy) begin
        addr <= addr + 1'b1;
        if (addr == LAST) begin
          busy  <= 1'b0;
          fin_q <= 1'b1;
        end
      end
      if (spill_start) done <= 1'b0;
    end
  end
endmodule

// File: rtl/evbw_regs.sv
module evbw_regs
  import evbw_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int ADDR_W    = 6,
  parameter int CNT_W     = 16,
  parameter int REG_DW    = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        spill_start,
  input  logic                        event_end,
  input  logic                        clr_busy,
  input  logic                        clr_done,
  input  logic [NUM_LANES*ADDR_W-1:0] last_addrs,
  input  logic                        reg_wr,
  input  logic [REG_AW-1:0]           reg_addr,
  input  logic [REG_DW-1:0]           reg_wdata,
  output logic                        clr_start,
  output logic [CNT_W-1:0]            evt_count,
  output logic [REG_DW-1:0]           reg_rdata
);
  logic [REG_DW-1:0] rd_mux;

  assign clr_start = reg_wr && (reg_addr == RA_CTRL) && reg_wdata[CTRL_START_BIT];

  always_ff @(posedge clk) begin
    if (rst || spill_start) evt_count <= '0;
    else if (event_end)     evt_count <= evt_count + 1'b1;
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_LANES; i++) begin
      if (reg_addr == REG_AW'(i)) rd_mux = REG_DW'(last_addrs[i*ADDR_W +: ADDR_W]);
    end
    if (reg_addr == RA_CTRL) begin
      rd_mux[CTRL_DONE_BIT] = clr_done;
      rd_mux[CTRL_BUSY_BIT] = clr_busy;
    end
    if (reg_addr == RA_EVCNT) rd_mux = REG_DW'(evt_count);
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/evbank_writer.sv
module evbank_writer
  import evbw_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 6,
  parameter int CNT_W     = 16,
  parameter int REG_DW    = 32,
  parameter logic [DATA_W-1:0] NULL_WORD = '0,
  parameter logic [DATA_W-1:0] NULL_MASK = '1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        spill_start,
  input  logic [NUM_LANES-1:0]        lane_valid,
  input  logic [NUM_LANES-1:0]        lane_eoe,
  input  logic [NUM_LANES*DATA_W-1:0] lane_data,
  output logic [NUM_LANES-1:0]        mem_we,
  output logic [NUM_LANES*ADDR_W-1:0] mem_addr,
  output logic [NUM_LANES*DATA_W-1:0] mem_wdata,
  input  logic                        reg_wr,
  input  logic [3:0]                  reg_addr,
  input  logic [REG_DW-1:0]           reg_wdata,
  output logic [REG_DW-1:0]           reg_rdata
);
  logic                        clr_busy;
  logic                        clr_done;
  logic                        clr_start;
  logic [ADDR_W-1:0]           clr_addr;
  logic [NUM_LANES*ADDR_W-1:0] last_addrs;
  logic [CNT_W-1:0]            evt_count;
  logic                        event_end;

  assign event_end = lane_valid[0] && lane_eoe[0] && !clr_busy;

  evbw_clear #(.ADDR_W(ADDR_W)) u_clear (
    .clk(clk), .rst(rst), .start(clr_start), .spill_start(spill_start),
    .busy(clr_busy), .addr(clr_addr), .done(clr_done)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    evbw_lane #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NULL_WORD(NULL_WORD), .NULL_MASK(NULL_MASK)
    ) u_lane (
      .clk(clk), .rst(rst), .spill_start(spill_start),
      .clr_busy(clr_busy), .clr_addr(clr_addr),
      .in_valid(lane_valid[g]), .in_data(lane_data[g*DATA_W +: DATA_W]),
      .we(mem_we[g]), .addr(mem_addr[g*ADDR_W +: ADDR_W]),
      .wdata(mem_wdata[g*DATA_W +: DATA_W]),
      .last_addr(last_addrs[g*ADDR_W +: ADDR_W])
    );
  end

  evbw_regs #(
    .NUM_LANES(NUM_LANES), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_DW(REG_DW)
  ) u_regs (
    .clk(clk), .rst(rst), .spill_start(spill_start), .event_end(event_end),
    .clr_busy(clr_busy), .clr_done(clr_done), .last_addrs(last_addrs),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .clr_start(clr_start), .evt_count(evt_count), .reg_rdata(reg_rdata)
  );
endmodule

// File: rtl/evbw_checker.sv
module evbw_checker #(
  parameter int NUM_LANES = 4,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 6,
  parameter int CNT_W     = 16
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        spill_start,
  input logic                        busy,
  input logic                        done,
  input logic [NUM_LANES-1:0]        lane_valid,
  input logic [NUM_LANES*DATA_W-1:0] lane_data,
  input logic [NUM_LANES-1:0]        mem_we,
  input logic [NUM_LANES*ADDR_W-1:0] mem_addr,
  input logic [NUM_LANES*DATA_W-1:0] mem_wdata,
  input logic [ADDR_W-1:0]           last0,
  input logic [CNT_W-1:0]            count
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  p_clear_zero_all_r7: assert property (@(posedge clk) disable iff (rst)
    busy |=> (&mem_we) && (mem_wdata == '0));

  p_clear_step_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |=> mem_addr[ADDR_W-1:0] == $past(mem_addr[ADDR_W-1:0]) + 1'b1);

  p_done_after_last_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(mem_we[0]) && $past(mem_addr[ADDR_W-1:0]) == LAST);

  p_done_busy_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));

  p_null_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (lane_valid[0] && lane_data[DATA_W-1:0] == '0 && !busy && !spill_start) |=> $stable(last0));

  p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
    !spill_start |=> (count == $past(count)) || (count == $past(count) + 1'b1));

  p_spill_zero_r5: assert property (@(posedge clk) disable iff (rst)
    spill_start |=> (count == '0) && (last0 == '0) && !done);
endmodule

bind evbank_writer evbw_checker #(
  .NUM_LANES(NUM_LANES), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .spill_start(spill_start), .busy(clr_busy), .done(clr_done),
  .lane_valid(lane_valid), .lane_data(lane_data), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .last0(last_addrs[ADDR_W-1:0]), .count(evt_count)
);

// File: tb/evbank_writer_tb.sv
module evbank_writer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 4;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int RDW = 32;

  logic clk = 0, rst = 1, spill_start = 0;
  logic [NL-1:0] lane_valid = '0, lane_eoe = '0;
  logic [NL*DW-1:0] lane_data = '0;
  logic [NL-1:0] mem_we;
  logic [NL*AW-1:0] mem_addr;
  logic [NL*DW-1:0] mem_wdata;
  logic reg_wr = 0;
  logic [3:0] reg_addr = '0;
  logic [RDW-1:0] reg_wdata = '0, reg_rdata;

  int checks = 0, fails = 0;
  logic [AW+DW-1:0] expq [NL][$];
  int m_ptr [NL];
  int m_last [NL];
  int m_count = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evbank_writer #(.NUM_LANES(NL), .DATA_W(DW), .ADDR_W(AW), .REG_DW(RDW)) u_dut (
    .clk(clk), .rst(rst), .spill_start(spill_start), .lane_valid(lane_valid),
    .lane_eoe(lane_eoe), .lane_data(lane_data), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every write strobe must match the next queued item
  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < NL; i++) begin
        if (mem_we[i]) begin
          if (expq[i].size() == 0) check("R9 unexpected write", {mem_addr[i*AW +: AW], mem_wdata[i*DW +: DW]}, 64'hdead);
          else check("R1/R2/R7 write", {mem_addr[i*AW +: AW], mem_wdata[i*DW +: DW]}, expq[i].pop_front());
        end
      end
    end
  end

  task automatic model_reset();
    for (int i = 0; i < NL; i++) begin m_ptr[i] = 0; m_last[i] = 0; end
    m_count = 0;
  endtask

  // drive one cycle of lane traffic; push expectations (busy=1 means clear in progress)
  task automatic send(input logic [NL-1:0] v, input logic [NL-1:0] e,
                      input logic [NL*DW-1:0] d, input bit busy);
    @(negedge clk);
    lane_valid = v; lane_eoe = e; lane_data = d;
    if (!busy) begin
      for (int i = 0; i < NL; i++) if (v[i]) begin
        expq[i].push_back({AW'(m_ptr[i]), d[i*DW +: DW]});
        if (d[i*DW +: DW] != '0) begin m_last[i] = m_ptr[i]; m_ptr[i] = (m_ptr[i] + 1) % DEPTH; end
      end
      if (v[0] && e[0]) m_count++;
    end
    @(negedge clk);
    lane_valid = '0; lane_eoe = '0; lane_data = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [RDW-1:0] q);
    @(negedge clk); reg_addr = a;
    @(negedge clk); q = reg_rdata;
  endtask

  task automatic check_regs(input string tag);
    logic [RDW-1:0] q;
    for (int i = 0; i < NL; i++) begin
      rd(4'(i), q); check({tag, " R3 last addr"}, q, m_last[i]);
    end
    rd(4'd15, q); check({tag, " R4 event count"}, q, m_count);
  endtask

  task automatic pulse_spill();
    @(negedge clk); spill_start = 1;
    @(negedge clk); spill_start = 0;
    model_reset();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [RDW-1:0] q;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R11 reset state
    check("R11 no write after reset", mem_we, 0);
    check_regs("R11");
    rd(4'd4, q); check("R11 ctrl", q, 0);
    pulse_spill();

    // R1/R2: mix of real and null words, some lanes idle
    send(4'b1111, 4'b0000, {16'h4444, 16'h3333, 16'h2222, 16'h1111}, 0);
    send(4'b0101, 4'b0000, {16'h0000, 16'h0000, 16'h0000, 16'h0000}, 0);
    send(4'b1111, 4'b0001, {16'h4001, 16'h0000, 16'h2001, 16'h1001}, 0);
    send(4'b1010, 4'b1010, {16'h0000, 16'h0000, 16'h2002, 16'h0000}, 0); // R4 only other lanes eoe
    send(4'b0011, 4'b0001, {16'h0000, 16'h0000, 16'h2003, 16'h1002}, 0);
    check_regs("R1 R2");
    for (int k = 0; k < DEPTH + 2; k++)   // R1 pointer wraps on lane 3
      send(4'b1000, 4'b0000, {16'(16'h5000 + k), 48'h0}, 0);
    check_regs("R1 wrap");

    // R6/R7: start fast clear
    @(negedge clk); reg_wr = 1; reg_addr = 4'd4; reg_wdata = 32'h1;
    for (int i = 0; i < NL; i++)
      for (int a = 0; a < DEPTH; a++) expq[i].push_back({AW'(a), 16'h0});
    @(negedge clk); reg_wr = 0; reg_wdata = '0;
    // R9 traffic during clear is ignored
    lane_valid = 4'b1111; lane_eoe = 4'b1111; lane_data = {4{16'hbeef}};
    @(negedge clk);
    lane_valid = '0; lane_eoe = '0; lane_data = '0;
    rd(4'd4, q);
    check("R6 start bit reads 0", q[0], 0);
    check("R8 busy during clear", q[2], 1);
    check("R8 done low during clear", q[1], 0);
    repeat (DEPTH + 4) @(negedge clk);
    rd(4'd4, q); check("R8 done after clear", q, 32'h2);
    rd(4'd4, q); check("R8 done stable on reread", q, 32'h2);
    for (int i = 0; i < NL; i++) check("R7 clear scored in full", expq[i].size(), 0);
    check_regs("R9 R7 state kept");
    send(4'b0001, 4'b0000, {48'h0, 16'h7777}, 0);   // R7 pointer continues after clear
    check_regs("R7 pointer kept");

    // R5 spill start
    pulse_spill();
    check_regs("R5");
    rd(4'd4, q); check("R5 done cleared", q, 0);
    send(4'b1111, 4'b0001, {16'h0000, 16'h3100, 16'h2100, 16'h1100}, 0);
    send(4'b1111, 4'b0000, {16'h4200, 16'h3200, 16'h2200, 16'h1200}, 0);
    check_regs("R5 R10 new spill");
    repeat (3) @(negedge clk);
    for (int i = 0; i < NL; i++) check("R10 scoreboard drained", expq[i].size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule